// File: doc/BRIEF.md
# Serial receive glitch filter with mode control

This block cleans up the asynchronous receive line of a serial channel before it reaches the receiver's shift logic. The raw pin first passes through a two-flop synchronizer. While filtering is active, three sampling stages are clocked by a strobe running at sixteen times the bit rate. A new level reaches the internal receive signal only after all three stages agree on it, so a disturbance lasting one or two sample periods is discarded.

A byte-wide control register sits beside the filter. It holds the filter enable, the function select for the shared transmit pin, and a standby bit that freezes the channel. Filtering takes effect only when the enable is set and the channel's mode input reports asynchronous operation. In any other case the filter is bypassed and the internal receive signal follows the synchronized pin with a fixed three-cycle latency.

All signals here are level or strobe signals with no back-pressure, so there is no valid/ready pairing. A register write is accepted on every cycle in which `reg_we` is high, and `reg_rdata` always reflects the current register contents.

Top module: `rx_noise_filter`

## Requirements
- R1: Register bits 7..3 always read as 1. Writing any value to them has no effect on the read data.
- R2: Register bits 2..0 are the filter enable (bit 2), the transmit pin select (bit 1) and standby (bit 0). Each resets to 0, and a write with `reg_we` high loads them from `reg_wdata[2:0]`. The new value is visible on `reg_rdata` in the next cycle.
- R3: Filtering is active only when bit 2 is 1 and `sync_mode` is 0. Otherwise the filter is bypassed.
- R4: While filtering is active and standby is off, `rx_filt` changes only on a clock edge at which `sample_en` is high.
- R5: While filtering is active, a receive level held for three or more strobe periods reaches `rx_filt`. A level held for only one or two strobe periods never appears on `rx_filt`.
- R6: In bypass, `rx_filt` equals `rx_pin` delayed by exactly three clock edges, and pulses of any width pass through.
- R7: With pin select 0, `tx_oe` is 0 and `tx_out` is 1. With pin select 1, `tx_oe` is 1 and `tx_out` equals `tx_data`.
- R8: While standby is 1, `rx_filt` holds its value and strobes are ignored. Register reads and writes still work, and `standby` mirrors bit 0.
- R9: After reset, `rx_filt` is 1, `reg_rdata` is 8'hF8 and `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sample_en | input | 1 | One-cycle strobe at 16x the bit rate |
| sync_mode | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| rx_pin | input | 1 | Raw receive pin |
| rx_filt | output | 1 | Filtered internal receive signal |
| tx_data | input | 1 | Transmit data from the shifter |
| tx_oe | output | 1 | Shared pin output enable |
| tx_out | output | 1 | Shared pin output value |
| standby | output | 1 | Channel standby indication |

## Verification
On every cycle, the assertions check that the reserved bits read as ones, that written control bits appear one cycle later, and that the pin mux follows its select bit. They also check that the output is frozen in standby and moves only on a strobe edge while filtering. Only the bench scenarios can show the width-dependent outcome of a pulse: rejection of one- and two-sample glitches, acceptance at three, and the bypass latency. The bench also shows that the stages resume from their held state when standby is left.

// File: rtl/rxnf_pkg.sv
package rxnf_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned BIT_EN  = 2;
  localparam int unsigned BIT_SEL = 1;
  localparam int unsigned BIT_SBY = 0;
  localparam int unsigned CTL_W   = 3;
  localparam logic [REG_W-1:0] RSV_ONES = 8'hF8;

  typedef struct packed {
    logic nc_en;
    logic tx_sel;
    logic stby;
  } ctrl_t;
endpackage

// File: rtl/rxnf_ctrl_reg.sv
module rxnf_ctrl_reg
  import rxnf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ctrl_t            ctrl
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q.nc_en  <= wdata[BIT_EN];
      ctrl_q.tx_sel <= wdata[BIT_SEL];
      ctrl_q.stby   <= wdata[BIT_SBY];
    end
  end

  always_comb begin
    rdata          = RSV_ONES;
    rdata[BIT_EN]  = ctrl_q.nc_en;
    rdata[BIT_SEL] = ctrl_q.tx_sel;
    rdata[BIT_SBY] = ctrl_q.stby;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/rxnf_sync.sv
module rxnf_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] chain;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ff
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[DEPTH-1];
endmodule

// File: rtl/rxnf_vote_filter.sv
module rxnf_vote_filter #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic strobe,
  input  logic hold,
  input  logic active,
  output logic dout
);
  logic [STAGES-1:0] stg;
  logic              agree;
  logic              out_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b1;
        else if (strobe && !hold) begin
          if (i == 0) stg[i] <= din;
          else stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign agree = (&stg) | ~(|stg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b1;
    end else if (!hold) begin
      if (!active) out_q <= din;
      else if (strobe && agree) out_q <= stg[STAGES-1];
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/rx_noise_filter.sv
module rx_noise_filter
  import rxnf_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned VOTE_DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sample_en,
  input  logic             sync_mode,
  input  logic             rx_pin,
  output logic             rx_filt,
  input  logic             tx_data,
  output logic             tx_oe,
  output logic             tx_out,
  output logic             standby
);
  ctrl_t ctrl;
  logic  rx_sync;
  logic  filt_active;

  rxnf_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  rxnf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_pin),
    .dout  (rx_sync)
  );

  assign filt_active = ctrl.nc_en & ~sync_mode;

  rxnf_vote_filter #(.STAGES(VOTE_DEPTH)) u_vote (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (rx_sync),
    .strobe (sample_en),
    .hold   (ctrl.stby),
    .active (filt_active),
    .dout   (rx_filt)
  );

  assign tx_oe   = ctrl.tx_sel;
  assign tx_out  = ctrl.tx_sel ? tx_data : 1'b1;
  assign standby = ctrl.stby;
endmodule

// File: rtl/rxnf_checker.sv
module rxnf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       sample_en,
  input logic       sync_mode,
  input logic       rx_filt,
  input logic       tx_data,
  input logic       tx_oe,
  input logic       tx_out,
  input logic       standby
);
  AST_RSV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:3] == 5'h1F); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[2:0] == $past(reg_wdata[2:0])); // R2
  AST_FILT_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && !sync_mode && !reg_rdata[0] && !sample_en) |=> $stable(rx_filt)); // R4
  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[1] |-> (!tx_oe && tx_out)); // R7
  AST_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |-> (tx_oe && tx_out == tx_data)); // R7
  AST_STBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] |=> $stable(rx_filt)); // R8
  AST_STBY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    standby == reg_rdata[0]); // R8
endmodule

bind rx_noise_filter rxnf_checker u_rxnf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .sample_en (sample_en),
  .sync_mode (sync_mode),
  .rx_filt   (rx_filt),
  .tx_data   (tx_data),
  .tx_oe     (tx_oe),
  .tx_out    (tx_out),
  .standby   (standby)
);

// File: tb/rx_noise_filter_bench.sv
`timescale 1ns/1ps
module rx_noise_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sample_en = 1'b0;
  logic       sync_mode = 1'b0;
  logic       rx_pin = 1'b1;
  logic       rx_filt;
  logic       tx_data = 1'b0;
  logic       tx_oe;
  logic       tx_out;
  logic       standby;

  int n_chk = 0;
  int n_bad = 0;
  logic saw_low = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  rx_noise_filter u_rx_noise_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sample_en(sample_en), .sync_mode(sync_mode),
    .rx_pin(rx_pin), .rx_filt(rx_filt), .tx_data(tx_data), .tx_oe(tx_oe),
    .tx_out(tx_out), .standby(standby)
  );

  // strobe: one cycle high out of every four
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % 4;
      sample_en = (cnt == 0);
    end
  end

  always @(negedge clk) if (rx_filt === 1'b0) saw_low = 1'b1;

  function automatic logic [7:0] exp_rd(input logic [7:0] w);
    return 8'hF8 | (w & 8'h07);
  endfunction

  function automatic bit exp_pass(input int width, input bit en, input bit smode);
    return !(en && !smode) || (width >= 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic after_strobe();
    do @(posedge clk); while (sample_en !== 1'b1);
    @(negedge clk);
  endtask

  task automatic pulse(input int width, input bit en, input bit smode, input string req);
    wr(en ? 8'h04 : 8'h00);
    @(negedge clk); sync_mode = smode;
    repeat (5) after_strobe();
    saw_low = 1'b0;
    rx_pin = 1'b0;
    repeat (width) after_strobe();
    rx_pin = 1'b1;
    repeat (6) after_strobe();
    check(req, saw_low, exp_pass(width, en, smode));
    check(req, rx_filt, 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", rx_filt, 1'b1);
    check("R9", reg_rdata, 8'hF8);
    check("R9", tx_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 register behaviour
    wr(8'h00); check("R1", reg_rdata, exp_rd(8'h00));
    wr(8'hFF); check("R1", reg_rdata, exp_rd(8'hFF));
    wr(8'h05); check("R2", reg_rdata, exp_rd(8'h05));
    check("R8", standby, 1'b1);
    wr(8'h02); check("R2", reg_rdata, exp_rd(8'h02));

    // R7 pin mux
    tx_data = 1'b0; @(negedge clk);
    check("R7", {tx_oe, tx_out}, 2'b10);
    tx_data = 1'b1; @(negedge clk);
    check("R7", {tx_oe, tx_out}, 2'b11);
    wr(8'h00); tx_data = 1'b0; @(negedge clk);
    check("R7", {tx_oe, tx_out}, 2'b01);

    // R5 directed widths with filtering active
    pulse(1, 1'b1, 1'b0, "R5");
    pulse(2, 1'b1, 1'b0, "R5");
    pulse(3, 1'b1, 1'b0, "R5");
    // R3 bypass via sync mode and via enable off
    pulse(1, 1'b1, 1'b1, "R3");
    pulse(1, 1'b0, 1'b0, "R3");

    // R6 bypass latency of three edges
    wr(8'h00); sync_mode = 1'b0;
    repeat (4) @(negedge clk);
    rx_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R6", rx_filt, 1'b1);
    @(negedge clk);
    check("R6", rx_filt, 1'b0);
    rx_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", rx_filt, 1'b1);

    // R8 standby freezes the filter; register still usable
    wr(8'h05);
    check("R8", reg_rdata, 8'hFD);
    repeat (2) after_strobe();
    saw_low = 1'b0;
    rx_pin = 1'b0;
    repeat (8) after_strobe();
    check("R8", saw_low, 1'b0);
    wr(8'h07); check("R8", reg_rdata, 8'hFF);
    wr(8'h04);
    repeat (5) after_strobe();
    check("R8", rx_filt, 1'b0);
    rx_pin = 1'b1;
    repeat (6) after_strobe();
    check("R8", rx_filt, 1'b1);

    // random widths and modes
    for (int i = 0; i < 24; i++) begin
      int w = int'($urandom % 6) + 1;
      bit e = 1'($urandom % 4 != 0);
      bit s = 1'($urandom % 4 == 0);
      pulse(w, e, s, (e && !s) ? "R5" : "R3");
    end

    // random register patterns
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v = 8'($urandom);
      v[0] = 1'b0;
      wr(v);
      check("R1", reg_rdata, exp_rd(v));
    end

    done = 1'b1;
    summary();
  end
endmodule